// File: doc/BRIEF.md
# Debug Matchpoint Comparator Array

This block is the compare stage of a processor debug unit. It keeps eight matchpoints, each made of a value register and an 8-bit control word. On every cycle the processor presents one access event: a 3-bit kind code and a data word. The kind code says whether the word is a fetch address, a load or store address, or load or store data. Each matchpoint decides on its own whether that event concerns it and whether the value passes its test against the stored value.

The result is an 8-bit match vector, one bit per matchpoint, together with a single any-match flag. Later stages use the any-match flag to skip chaining, counting and break logic when nothing matched. The outputs are purely combinational from the current event and the register contents.

The registers are loaded through a single write port. The port carries an index, a select that picks the value or the control word, and a data word. A write takes effect at the clock edge that samples it.

Top module: `mp_array`

## Requirements
- R1: While rst_ni is low and after its release, all value and control registers are zero, so match_o is all-zero for any event.
- R2: A matchpoint whose control bit 0 (enable) is 0 never sets its match_o bit.
- R3: Control bits 7:5 select the watched kind: 1 fetch address, 2 load address, 3 store address, 4 load data, 5 store data, 6 load or store address, 7 load or store data, 0 none. The event code on ev_kind_i is 0 idle, 1 fetch address, 2 load address, 3 store address, 4 load data, 5 store data, 6 and 7 unused. A matchpoint fires only when its selected kind covers the event code. Select 0, idle events and unused codes never fire.
- R4: With control bit 4 set, relational conditions compare ev_val_i and the value register as two's-complement numbers; with it clear, as unsigned numbers.
- R5: Control bits 3:1 code 1 fires when the event value equals the value register; code 6 fires when they differ.
- R6: Codes 2, 3, 4 and 5 fire when the event value is respectively less than, less than or equal to, greater than, or greater than or equal to the value register.
- R7: Code 0 (masked) fires when the bitwise AND of the event value and the value register is non-zero, whatever bit 4 holds.
- R8: Condition code 7 never fires.
- R9: any_match_o is 1 exactly when at least one bit of match_o is 1.
- R10: With cfg_we_i high at a rising edge, cfg_data_i is loaded into the register of matchpoint cfg_idx_i, into its control word (low 8 bits) when cfg_sel_i is 1 and into its value register when cfg_sel_i is 0. No other register changes, and no register changes at an edge where cfg_we_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 1 selects the control word, 0 the value register |
| cfg_idx_i | input | 3 | Matchpoint index of the write |
| cfg_data_i | input | 32 | Write data |
| ev_kind_i | input | 3 | Kind code of the current access event |
| ev_val_i | input | 32 | Address or data word of the current event |
| match_o | output | 8 | Per-matchpoint match result |
| any_match_o | output | 1 | OR of all match bits |

## Verification
The bench walks all 256 control words across the eight matchpoints. For each one it applies every event code against value pairs chosen around zero, the sign bit and an all-ones word, and checks each match bit against an arithmetic model.

The pairs are chosen to catch specific faults. A signed/unsigned mix-up shows up on pairs where 0x8000_0000 and 0xFFFF_FFF0 order differently from small positive values. An off-by-one between less-than and less-or-equal shows up on equal operands. A masked test wrongly built as an equality test shows up on 0x11 against 0x10.

The combined kinds 6 and 7 are checked against every event code, so a decoder that drops one half of the pair, or fires on idle or unused codes, fails. A separate write sequence shows that one index or select updates only its own register.

// File: rtl/mp_pkg.sv
package mp_pkg;

  typedef enum logic [2:0] {
    CMP_MASK = 3'd0,
    CMP_EQ   = 3'd1,
    CMP_LT   = 3'd2,
    CMP_LE   = 3'd3,
    CMP_GT   = 3'd4,
    CMP_GE   = 3'd5,
    CMP_NE   = 3'd6,
    CMP_NONE = 3'd7
  } cond_e;

  typedef enum logic [2:0] {
    W_OFF   = 3'd0,
    W_FETCH = 3'd1,
    W_LDA   = 3'd2,
    W_STA   = 3'd3,
    W_LDD   = 3'd4,
    W_STD   = 3'd5,
    W_LSA   = 3'd6,
    W_LSD   = 3'd7
  } watch_e;

  localparam logic [2:0] EV_IDLE  = 3'd0;
  localparam logic [2:0] EV_FETCH = 3'd1;
  localparam logic [2:0] EV_LDA   = 3'd2;
  localparam logic [2:0] EV_STA   = 3'd3;
  localparam logic [2:0] EV_LDD   = 3'd4;
  localparam logic [2:0] EV_STD   = 3'd5;

  // bit 7:5 kind, 4 signed, 3:1 condition, 0 enable
  typedef struct packed {
    watch_e kind;
    logic   sgn;
    cond_e  cond;
    logic   en;
  } mp_ctrl_t;

  localparam int unsigned CTRL_W = $bits(mp_ctrl_t);
  localparam int unsigned KIND_W = 3;

endpackage

// File: rtl/mp_cfg_regs.sv
module mp_cfg_regs
  import mp_pkg::*;
#(
  parameter int unsigned NUM_MP = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (NUM_MP > 1) ? $clog2(NUM_MP) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic                       sel_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic [NUM_MP*DATA_W-1:0]   val_flat_o,
  output logic [NUM_MP*CTRL_W-1:0]   ctrl_flat_o
);

  for (genvar i = 0; i < NUM_MP; i++) begin : g_ent
    logic hit;
    assign hit = we_i && (idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_flat_o[i*DATA_W +: DATA_W]  <= '0;
        ctrl_flat_o[i*CTRL_W +: CTRL_W] <= '0;
      end else if (hit) begin
        if (sel_i) ctrl_flat_o[i*CTRL_W +: CTRL_W] <= data_i[CTRL_W-1:0];
        else       val_flat_o[i*DATA_W +: DATA_W]  <= data_i;
      end
    end
  end

endmodule

// File: rtl/mp_kind_match.sv
module mp_kind_match
  import mp_pkg::*;
(
  input  watch_e            sel_i,
  input  logic [KIND_W-1:0] ev_kind_i,
  output logic              hit_o
);

  always_comb begin
    unique case (sel_i)
      W_FETCH: hit_o = (ev_kind_i == EV_FETCH);
      W_LDA:   hit_o = (ev_kind_i == EV_LDA);
      W_STA:   hit_o = (ev_kind_i == EV_STA);
      W_LDD:   hit_o = (ev_kind_i == EV_LDD);
      W_STD:   hit_o = (ev_kind_i == EV_STD);
      W_LSA:   hit_o = (ev_kind_i == EV_LDA) || (ev_kind_i == EV_STA);
      W_LSD:   hit_o = (ev_kind_i == EV_LDD) || (ev_kind_i == EV_STD);
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/mp_compare.sv
module mp_compare
  import mp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sgn_i,
  input  cond_e             cond_i,
  output logic              res_o
);

  // one extended subtractor-style compare serves both signednesses
  logic signed [DATA_W:0] ax, bx;
  logic eq, lt;

  assign ax = {sgn_i & a_i[DATA_W-1], a_i};
  assign bx = {sgn_i & b_i[DATA_W-1], b_i};
  assign eq = (a_i == b_i);
  assign lt = (ax < bx);

  always_comb begin
    unique case (cond_i)
      CMP_MASK: res_o = |(a_i & b_i);
      CMP_EQ:   res_o = eq;
      CMP_NE:   res_o = !eq;
      CMP_LT:   res_o = lt;
      CMP_LE:   res_o = lt | eq;
      CMP_GT:   res_o = !lt & !eq;
      CMP_GE:   res_o = !lt;
      default:  res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/mp_array.sv
module mp_array
  import mp_pkg::*;
#(
  parameter int unsigned NUM_MP = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (NUM_MP > 1) ? $clog2(NUM_MP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic [2:0]        ev_kind_i,
  input  logic [DATA_W-1:0] ev_val_i,
  output logic [NUM_MP-1:0] match_o,
  output logic              any_match_o
);

  logic [NUM_MP*DATA_W-1:0] val_flat;
  logic [NUM_MP*CTRL_W-1:0] ctrl_flat;

  mp_cfg_regs #(.NUM_MP(NUM_MP), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .idx_i      (cfg_idx_i),
    .data_i     (cfg_data_i),
    .val_flat_o (val_flat),
    .ctrl_flat_o(ctrl_flat)
  );

  for (genvar i = 0; i < NUM_MP; i++) begin : g_mp
    mp_ctrl_t ctl;
    logic     kind_hit, cmp_hit;

    assign ctl = mp_ctrl_t'(ctrl_flat[i*CTRL_W +: CTRL_W]);

    mp_kind_match u_kind (
      .sel_i    (ctl.kind),
      .ev_kind_i(ev_kind_i),
      .hit_o    (kind_hit)
    );

    mp_compare #(.DATA_W(DATA_W)) u_cmp (
      .a_i   (ev_val_i),
      .b_i   (val_flat[i*DATA_W +: DATA_W]),
      .sgn_i (ctl.sgn),
      .cond_i(ctl.cond),
      .res_o (cmp_hit)
    );

    assign match_o[i] = ctl.en & kind_hit & cmp_hit;
  end

  assign any_match_o = |match_o;

endmodule

// File: rtl/mp_array_chk.sv
module mp_array_chk
  import mp_pkg::*;
#(
  parameter int unsigned NUM_MP = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cfg_we_i,
  input logic [2:0]               ev_kind_i,
  input logic [NUM_MP*CTRL_W-1:0] ctrl_flat,
  input logic [NUM_MP-1:0]        match_o,
  input logic                     any_match_o
);

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (match_o == '0));

  a_r9_any_is_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_match_o == (match_o != '0));

  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_kind_i == EV_IDLE || ev_kind_i > EV_STD) |-> (match_o == '0));

  a_r10_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(ctrl_flat));

  for (genvar i = 0; i < NUM_MP; i++) begin : g_chk
    a_r2_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_flat[i*CTRL_W] |-> !match_o[i]);

    a_r3_none_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_flat[i*CTRL_W+7 -: 3] == 3'd0) |-> !match_o[i]);

    a_r8_cond7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_flat[i*CTRL_W+3 -: 3] == 3'd7) |-> !match_o[i]);
  end

endmodule

bind mp_array mp_array_chk #(.NUM_MP(NUM_MP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .ev_kind_i  (ev_kind_i),
  .ctrl_flat  (ctrl_flat),
  .match_o    (match_o),
  .any_match_o(any_match_o)
);

// File: tb/mp_array_test.sv
module mp_array_test;

  localparam int NMP = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic [2:0]  ev_kind_i = '0;
  logic [31:0] ev_val_i = '0;
  logic [7:0]  match_o;
  logic        any_match_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  mp_array uut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_idx_i, .cfg_data_i,
    .ev_kind_i, .ev_val_i, .match_o, .any_match_o
  );

  logic [31:0] dvals [3] = '{32'h0000_0010, 32'h8000_0000, 32'hFFFF_FFF0};
  logic [31:0] evals [6] = '{32'h0, 32'h10, 32'h11, 32'h0F, 32'h8000_0000, 32'hFFFF_FFFF};

  function automatic bit kind_ok(logic [2:0] t, logic [2:0] k);
    case (t)
      3'd1: return k == 3'd1;
      3'd2: return k == 3'd2;
      3'd3: return k == 3'd3;
      3'd4: return k == 3'd4;
      3'd5: return k == 3'd5;
      3'd6: return k == 3'd2 || k == 3'd3;
      3'd7: return k == 3'd4 || k == 3'd5;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_bit(logic [7:0] c, logic [31:0] v, logic [2:0] k, logic [31:0] e);
    bit less, same;
    if (!c[0] || !kind_ok(c[7:5], k)) return 1'b0;
    same = (e == v);
    less = c[4] ? ($signed(e) < $signed(v)) : (e < v);
    case (c[3:1])
      3'd0: return (e & v) != 0;
      3'd1: return same;
      3'd2: return less;
      3'd3: return less || same;
      3'd4: return !less && !same;
      3'd5: return !less;
      3'd6: return !same;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] c, logic [2:0] k);
    if (!c[0]) return "R2";
    if (!kind_ok(c[7:5], k)) return "R3";
    if (c[3:1] == 3'd7) return "R8";
    if (c[3:1] == 3'd0) return "R7";
    if (c[3:1] == 3'd1 || c[3:1] == 3'd6) return "R5";
    if (c[4]) return "R4";
    return "R6";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit sel, int idx, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_idx_i = 3'(idx); cfg_data_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic ev(logic [2:0] k, logic [31:0] v);
    ev_kind_i = k; ev_val_i = v;
    #5;
  endtask

  initial begin
    logic [7:0]  cw [NMP];
    logic [31:0] vw [NMP];
    // R1: reset state
    #5;
    for (int k = 0; k < 8; k++) begin
      ev(3'(k), 32'hFFFF_FFFF);
      check("R1 in reset", match_o, 0);
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 8; k++) begin
      ev(3'(k), 32'h0);
      check("R1 after reset", match_o, 0);
      check("R9 after reset", any_match_o, 0);
    end

    // R10: targeted writes (0x23 = fetch, equal, unsigned, enabled)
    for (int i = 0; i < NMP; i++) begin
      wr(1'b0, i, 32'(i) * 32'h100);
      wr(1'b1, i, 32'h23);
    end
    ev(3'd1, 32'h300);
    check("R10 value per index", match_o, 8'h08);
    wr(1'b0, 5, 32'h300);
    ev(3'd1, 32'h300);
    check("R10 value write isolated", match_o, 8'h28);
    wr(1'b1, 3, 32'h22);
    ev(3'd1, 32'h300);
    check("R10 control write isolated", match_o, 8'h20);
    check("R9 single", any_match_o, 1);
    @(negedge clk_i);
    cfg_sel_i = 1'b1; cfg_idx_i = 3'd5; cfg_data_i = 32'h0;
    @(negedge clk_i);
    ev(3'd1, 32'h300);
    check("R10 no write without strobe", match_o, 8'h20);

    // sweep every control word
    for (int r = 0; r < 32; r++) begin
      for (int s = 0; s < 3; s++) begin
        for (int i = 0; i < NMP; i++) begin
          cw[i] = 8'(r * NMP + i);
          vw[i] = dvals[(s + i) % 3];
          wr(1'b1, i, {24'h0, cw[i]});
          wr(1'b0, i, vw[i]);
        end
        for (int k = 0; k < 8; k++) begin
          for (int e = 0; e < 6; e++) begin
            logic [7:0] expv;
            ev(3'(k), evals[e]);
            for (int i = 0; i < NMP; i++) begin
              expv[i] = exp_bit(cw[i], vw[i], 3'(k), evals[e]);
              check(tag_of(cw[i], 3'(k)), 32'(match_o[i]), 32'(expv[i]));
            end
            check("R9 any", any_match_o, 32'(expv != 0));
            @(negedge clk_i);
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule